// File: doc/BRIEF.md
# Flash Bus Cycle Decoder

This block is the device-side front end of a parallel NAND-style flash bus. It runs on an internal system clock. The control pins are chip enable, command latch, address latch, read enable, write enable and write protect. These pins and the I/O bus reach the block asynchronously, so all of them pass through one shared two-flop synchroniser. A rising edge of write enable marks a bus write. At that edge the levels of the latch enables decide whether the cycle carries a command, an address byte or a data word. The block then emits a one-clock strobe carrying the captured value.

Address bytes are collected into a single address word. The number of address bytes is a parameter: 3 for small parts and 4 for large ones. Program and erase opcodes are blocked for as long as write protect is held low. On the read side, the block raises an output enable while the bus is in an output cycle. It fetches the next word from an internal read port after every falling edge of read enable. While chip enable is high the block is in standby and ignores every cycle. The pin pulses are assumed to be at least three system clocks wide.

Top module: `nand_bus_front`

## Requirements
- R1: A write-enable rising edge seen with chip enable low, read enable high, command latch high and address latch low gives one `cmd_stb` pulse. `cmd_byte` then equals I/O bits 7:0; bits 15:8 are ignored.
- R2: Address cycles use the same conditions as R1 but with address latch high and command latch low. Each one stores I/O bits 7:0 as the next address byte, with the first byte in bits 7:0 of `addr_word`. Only the ADDR_CYCLES-th byte raises `addr_stb`.
- R3: A write-enable rising edge with chip enable, both latch enables low and read enable high gives one `data_stb` pulse. `data_word` then equals the full DW-bit I/O value.
- R4: A write-enable rising edge while read enable is low, or while both latch enables are high, produces no strobe of any kind. No two of the five event outputs are ever high in the same clock.
- R5: While chip enable is high, `standby` is high, `io_oe` is low, and neither write-enable nor read-enable edges have any effect.
- R6: Every accepted command cycle clears the address byte count, so a partial address is discarded.
- R7: An address cycle that arrives after the count is already full pulses `addr_err`. It does not pulse `addr_stb`.
- R8: With write protect low, the opcodes 0x80, 0x10, 0x60 and 0xD0 pulse `cmd_reject` instead of `cmd_stb`. All other opcodes still pass. With write protect high, every opcode passes.
- R9: `io_oe` is high exactly while the synchronised bus shows chip enable low, write enable high and both latch enables low, one clock later than that bus state.
- R10: Each read-enable falling edge inside an output cycle pulses `rd_req` once. One clock later, `io_out` holds the `rd_data` value that was present during that pulse. At all other times `io_out` holds its value.
- R11: After reset, every strobe, `rd_req` and `io_oe` are low and `io_out` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable pin, active low |
| cle | input | 1 | Command latch pin |
| ale | input | 1 | Address latch pin |
| re_n | input | 1 | Read enable pin, active low |
| we_n | input | 1 | Write enable pin, active low |
| wp_n | input | 1 | Write protect pin, active low |
| io_in | input | DW | I/O bus input |
| io_out | output | DW | Output data register |
| io_oe | output | 1 | Output driver enable |
| rd_data | input | DW | Next word from the internal read port |
| rd_req | output | 1 | Read port advance request |
| cmd_stb | output | 1 | Accepted command strobe |
| cmd_byte | output | 8 | Captured opcode |
| cmd_reject | output | 1 | Protected opcode refused |
| addr_stb | output | 1 | Complete address strobe |
| addr_word | output | 8*ADDR_CYCLES | Assembled address |
| addr_err | output | 1 | Surplus address cycle |
| data_stb | output | 1 | Data input strobe |
| data_word | output | DW | Captured data |
| standby | output | 1 | Synchronised chip-enable high |

## Verification
The bench sweeps every combination of chip enable, both latch enables and read enable around a write strobe. This catches a decoder that ignores read enable or lets a conflicting latch pair through; such a decoder would emit a strobe where none is allowed. It then sends all 256 opcodes with write protect low. A wrong protected set would refuse a harmless opcode or let an erase through. It also runs short, surplus and interrupted address sequences. A counter that does not clear on a command, or that wraps instead of flagging, would produce an address word built from stale bytes. Finally, it steps reads against a counting data model, both inside and outside an output cycle. A loader that is off by one clock or that runs in standby would show the wrong word.

// File: rtl/nbf_pkg.sv
package nbf_pkg;

    typedef enum logic [1:0] {
        CYC_NONE = 2'd0,
        CYC_CMD  = 2'd1,
        CYC_ADDR = 2'd2,
        CYC_DATA = 2'd3
    } cyc_kind_t;

    typedef struct packed {
        logic ce_n;
        logic cle;
        logic ale;
        logic re_n;
        logic we_n;
        logic wp_n;
    } ctl_pins_t;

    localparam int CTL_W = 6;

    // Pin levels assumed while reset holds: deselected, no strobes, protected.
    localparam ctl_pins_t CTL_IDLE = '{ce_n: 1'b1, cle: 1'b0, ale: 1'b0,
                                       re_n: 1'b1, we_n: 1'b1, wp_n: 1'b0};

    function automatic logic is_modify_op(input logic [7:0] op);
        return (op == 8'h80) || (op == 8'h10) || (op == 8'h60) || (op == 8'hD0);
    endfunction

    function automatic cyc_kind_t classify(input ctl_pins_t p);
        cyc_kind_t k;
        if (p.ce_n || !p.re_n) begin
            k = CYC_NONE;
        end else begin
            unique case ({p.cle, p.ale})
                2'b10:   k = CYC_CMD;
                2'b01:   k = CYC_ADDR;
                2'b00:   k = CYC_DATA;
                default: k = CYC_NONE;
            endcase
        end
        return k;
    endfunction

    function automatic logic output_window(input ctl_pins_t p);
        return !p.ce_n && p.we_n && !p.cle && !p.ale;
    endfunction

endpackage

// File: rtl/nbf_sync.sv
module nbf_sync #(
    parameter int           W       = 8,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/nbf_cycle_decode.sv
module nbf_cycle_decode
    import nbf_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  ctl_pins_t         ctl,
    input  logic [DW-1:0]     io,
    output cyc_kind_t         ev_kind,
    output logic [DW-1:0]     ev_word,
    output logic              re_fall,
    output logic              out_cond
);
    logic we_q;
    logic re_q;
    logic we_rise;

    assign we_rise  = ctl.we_n && !we_q;
    assign re_fall  = !ctl.re_n && re_q;
    assign out_cond = output_window(ctl);

    always_ff @(posedge clk) begin
        if (rst) begin
            we_q    <= 1'b1;
            re_q    <= 1'b1;
            ev_kind <= CYC_NONE;
            ev_word <= '0;
        end else begin
            we_q    <= ctl.we_n;
            re_q    <= ctl.re_n;
            ev_kind <= we_rise ? classify(ctl) : CYC_NONE;
            if (we_rise) begin
                ev_word <= io;
            end
        end
    end
endmodule

// File: rtl/nbf_addr_gather.sv
module nbf_addr_gather
    import nbf_pkg::*;
#(
    parameter int ADDR_CYCLES = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  cyc_kind_t                ev_kind,
    input  logic [7:0]               ev_byte,
    output logic                     addr_stb,
    output logic [8*ADDR_CYCLES-1:0] addr_word,
    output logic                     addr_err
);
    localparam int            CW   = $clog2(ADDR_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(ADDR_CYCLES - 1);
    localparam logic [CW-1:0] FULL = CW'(ADDR_CYCLES);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt       <= '0;
            addr_stb  <= 1'b0;
            addr_err  <= 1'b0;
            addr_word <= '0;
        end else begin
            addr_stb <= 1'b0;
            addr_err <= 1'b0;
            if (ev_kind == CYC_CMD) begin
                cnt <= '0;
            end else if (ev_kind == CYC_ADDR) begin
                if (cnt == FULL) begin
                    addr_err <= 1'b1;
                end else begin
                    addr_word[int'(cnt)*8 +: 8] <= ev_byte;
                    cnt <= cnt + 1'b1;
                    if (cnt == LAST) begin
                        addr_stb <= 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/nbf_read_port.sv
module nbf_read_port #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          out_cond,
    input  logic          re_fall,
    input  logic [DW-1:0] rd_data,
    output logic          rd_req,
    output logic          io_oe,
    output logic [DW-1:0] io_out
);
    always_ff @(posedge clk) begin
        if (rst) begin
            io_oe  <= 1'b0;
            rd_req <= 1'b0;
            io_out <= '0;
        end else begin
            io_oe  <= out_cond;
            rd_req <= re_fall && out_cond;
            if (rd_req) begin
                io_out <= rd_data;
            end
        end
    end
endmodule

// File: rtl/nand_bus_front.sv
module nand_bus_front
    import nbf_pkg::*;
#(
    parameter int DW          = 8,
    parameter int ADDR_CYCLES = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     ce_n,
    input  logic                     cle,
    input  logic                     ale,
    input  logic                     re_n,
    input  logic                     we_n,
    input  logic                     wp_n,
    input  logic [DW-1:0]            io_in,
    output logic [DW-1:0]            io_out,
    output logic                     io_oe,
    input  logic [DW-1:0]            rd_data,
    output logic                     rd_req,
    output logic                     cmd_stb,
    output logic [7:0]               cmd_byte,
    output logic                     cmd_reject,
    output logic                     addr_stb,
    output logic [8*ADDR_CYCLES-1:0] addr_word,
    output logic                     addr_err,
    output logic                     data_stb,
    output logic [DW-1:0]            data_word,
    output logic                     standby
);
    localparam int                SW      = CTL_W + DW;
    localparam logic [SW-1:0]     SYNC_RV = {CTL_IDLE, {DW{1'b0}}};

    logic [SW-1:0] pins_s;
    ctl_pins_t     ctl_s;
    logic [DW-1:0] io_s;
    logic          wp_s;
    cyc_kind_t     ev_kind;
    logic [DW-1:0] ev_word;
    logic          re_fall;
    logic          out_cond;

    nbf_sync #(.W(SW), .RST_VAL(SYNC_RV)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({ce_n, cle, ale, re_n, we_n, wp_n, io_in}),
        .q   (pins_s)
    );

    assign ctl_s   = ctl_pins_t'(pins_s[DW +: CTL_W]);
    assign io_s    = pins_s[DW-1:0];
    assign wp_s    = ctl_s.wp_n;
    assign standby = ctl_s.ce_n;

    nbf_cycle_decode #(.DW(DW)) u_dec (
        .clk      (clk),
        .rst      (rst),
        .ctl      (ctl_s),
        .io       (io_s),
        .ev_kind  (ev_kind),
        .ev_word  (ev_word),
        .re_fall  (re_fall),
        .out_cond (out_cond)
    );

    nbf_addr_gather #(.ADDR_CYCLES(ADDR_CYCLES)) u_addr (
        .clk       (clk),
        .rst       (rst),
        .ev_kind   (ev_kind),
        .ev_byte   (ev_word[7:0]),
        .addr_stb  (addr_stb),
        .addr_word (addr_word),
        .addr_err  (addr_err)
    );

    nbf_read_port #(.DW(DW)) u_rd (
        .clk      (clk),
        .rst      (rst),
        .out_cond (out_cond),
        .re_fall  (re_fall),
        .rd_data  (rd_data),
        .rd_req   (rd_req),
        .io_oe    (io_oe),
        .io_out   (io_out)
    );

    // Command gate: protected opcodes are refused while write protect is low.
    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_stb    <= 1'b0;
            cmd_reject <= 1'b0;
            cmd_byte   <= '0;
            data_stb   <= 1'b0;
            data_word  <= '0;
        end else begin
            cmd_stb    <= 1'b0;
            cmd_reject <= 1'b0;
            data_stb   <= 1'b0;
            if (ev_kind == CYC_CMD) begin
                cmd_byte <= ev_word[7:0];
                if (is_modify_op(ev_word[7:0]) && !wp_s) begin
                    cmd_reject <= 1'b1;
                end else begin
                    cmd_stb <= 1'b1;
                end
            end
            if (ev_kind == CYC_DATA) begin
                data_stb  <= 1'b1;
                data_word <= ev_word;
            end
        end
    end
endmodule

// File: rtl/nbf_checker.sv
module nbf_checker
    import nbf_pkg::*;
#(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          cmd_stb,
    input logic          cmd_reject,
    input logic [7:0]    cmd_byte,
    input logic          addr_stb,
    input logic          addr_err,
    input logic          data_stb,
    input logic          standby,
    input logic          io_oe,
    input logic          rd_req,
    input logic          wp_s,
    input logic [DW-1:0] rd_data,
    input logic [DW-1:0] io_out
);
    assert_one_event_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cmd_stb, cmd_reject, addr_stb, addr_err, data_stb}));

    assert_reject_protected_R8: assert property (@(posedge clk) disable iff (rst)
        cmd_reject |-> ($past(!wp_s) && is_modify_op(cmd_byte)));

    assert_modify_allowed_R8: assert property (@(posedge clk) disable iff (rst)
        (cmd_stb && is_modify_op(cmd_byte)) |-> $past(wp_s));

    assert_standby_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        standby |=> !io_oe);

    assert_req_in_window_R9: assert property (@(posedge clk) disable iff (rst)
        rd_req |-> io_oe);

    assert_step_load_R10: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> (io_out == $past(rd_data)));

    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!rd_req && !$past(rd_req)) |=> $stable(io_out));
endmodule

bind nand_bus_front nbf_checker #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cmd_stb    (cmd_stb),
    .cmd_reject (cmd_reject),
    .cmd_byte   (cmd_byte),
    .addr_stb   (addr_stb),
    .addr_err   (addr_err),
    .data_stb   (data_stb),
    .standby    (standby),
    .io_oe      (io_oe),
    .rd_req     (rd_req),
    .wp_s       (wp_s),
    .rd_data    (rd_data),
    .io_out     (io_out)
);

// File: tb/nand_bus_front_test.sv
module nand_bus_front_test;
    localparam int DW = 16;
    localparam int NC = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ce_n = 1'b1, cle = 1'b0, ale = 1'b0, re_n = 1'b1, we_n = 1'b1, wp_n = 1'b1;
    logic [DW-1:0] io_in = '0;
    logic [DW-1:0] io_out, rd_data, data_word;
    logic io_oe, rd_req, cmd_stb, cmd_reject, addr_stb, addr_err, data_stb, standby;
    logic [7:0] cmd_byte;
    logic [8*NC-1:0] addr_word;

    int n_checks = 0;
    int n_fail = 0;
    int rd_idx = 0;
    int c_cmd = 0, c_rej = 0, c_addr = 0, c_aerr = 0, c_data = 0, c_req = 0;
    logic [7:0] last_cmd = '0;
    logic [8*NC-1:0] last_addr = '0;
    logic [DW-1:0] last_data = '0;

    always #4 clk = ~clk;

    function automatic logic [DW-1:0] model(input int k);
        return DW'(k * 16'h0123 + 16'h00A5);
    endfunction
    assign rd_data = model(rd_idx);

    always @(posedge clk) if (!rst && rd_req) rd_idx <= rd_idx + 1;

    always @(negedge clk) if (!rst) begin
        if (cmd_stb)    begin c_cmd++;  last_cmd  = cmd_byte;  end
        if (cmd_reject) begin c_rej++;  last_cmd  = cmd_byte;  end
        if (addr_stb)   begin c_addr++; last_addr = addr_word; end
        if (addr_err)   c_aerr++;
        if (data_stb)   begin c_data++; last_data = data_word; end
        if (rd_req)     c_req++;
    end

    nand_bus_front #(.DW(DW), .ADDR_CYCLES(NC)) uut (
        .clk(clk), .rst(rst), .ce_n(ce_n), .cle(cle), .ale(ale), .re_n(re_n),
        .we_n(we_n), .wp_n(wp_n), .io_in(io_in), .io_out(io_out), .io_oe(io_oe),
        .rd_data(rd_data), .rd_req(rd_req), .cmd_stb(cmd_stb), .cmd_byte(cmd_byte),
        .cmd_reject(cmd_reject), .addr_stb(addr_stb), .addr_word(addr_word),
        .addr_err(addr_err), .data_stb(data_stb), .data_word(data_word),
        .standby(standby)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic e, input logic c, input logic a, input logic r,
                             input logic [DW-1:0] d);
        ce_n = e; cle = c; ale = a; re_n = r; io_in = d;
        wait_n(4);
        we_n = 1'b0;
        wait_n(4);
        we_n = 1'b1;
        wait_n(4);
        cle = 1'b0; ale = 1'b0; re_n = 1'b1;
        wait_n(6);
    endtask

    // Expected kind from the bus rules: 0 none, 1 command, 2 address, 3 data.
    function automatic int exp_kind(input logic e, input logic c, input logic a, input logic r);
        if (e || !r) return 0;
        if (c && !a) return 1;
        if (a && !c) return 2;
        if (!a && !c) return 3;
        return 0;
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        int s_cmd, s_rej, s_addr, s_aerr, s_data, s_req, base;
        logic [DW-1:0] held;
        wait_n(3);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk(!cmd_stb && !cmd_reject && !addr_stb && !addr_err && !data_stb && !rd_req,
            "R11 strobes", 0, 0);
        chk(io_oe == 1'b0, "R11 io_oe", io_oe, 0);
        chk(io_out == '0, "R11 io_out", io_out, 0);
        wait_n(4);
        chk(standby == 1'b1, "R5 standby idle", standby, 1);

        // R1 R3 R4 R5: sweep every chip enable / latch / read enable combination
        for (int i = 0; i < 16; i++) begin
            logic e, c, a, r;
            logic [DW-1:0] d;
            int k;
            {e, c, a, r} = 4'(i);
            d = 16'hA540 + 16'(i);
            k = exp_kind(e, c, a, r);
            s_cmd = c_cmd; s_addr = c_addr; s_aerr = c_aerr; s_data = c_data; s_rej = c_rej;
            bus_write(e, c, a, r, d);
            chk((c_cmd - s_cmd) == (k == 1 ? 1 : 0), "R1/R4/R5 cmd count", c_cmd - s_cmd, k == 1);
            chk((c_data - s_data) == (k == 3 ? 1 : 0), "R3/R4/R5 data count", c_data - s_data, k == 3);
            chk(c_addr == s_addr && c_aerr == s_aerr && c_rej == s_rej,
                "R4 no address or reject event", c_addr - s_addr, 0);
            if (k == 1) chk(last_cmd == d[7:0], "R1 cmd byte low half", last_cmd, d[7:0]);
            if (k == 3) chk(last_data == d, "R3 full data word", last_data, d);
        end
        ce_n = 1'b1;
        wait_n(4);

        // R2 R6 R7: address assembly, restart on command, surplus cycle
        bus_write(1'b0, 1'b1, 1'b0, 1'b1, 16'h0000);
        s_addr = c_addr;
        bus_write(1'b0, 1'b0, 1'b1, 1'b1, 16'hFF11);
        bus_write(1'b0, 1'b0, 1'b1, 1'b1, 16'hFF22);
        chk(c_addr == s_addr, "R2 no strobe before last byte", c_addr - s_addr, 0);
        bus_write(1'b0, 1'b0, 1'b1, 1'b1, 16'hFF33);
        chk(c_addr - s_addr == 1, "R2 strobe on last byte", c_addr - s_addr, 1);
        chk(last_addr == 24'h332211, "R2 byte order, upper I/O ignored", last_addr, 24'h332211);
        s_aerr = c_aerr; s_addr = c_addr;
        bus_write(1'b0, 1'b0, 1'b1, 1'b1, 16'h0044);
        chk(c_aerr - s_aerr == 1 && c_addr == s_addr, "R7 surplus address flagged",
            c_aerr - s_aerr, 1);
        bus_write(1'b0, 1'b1, 1'b0, 1'b1, 16'h0000);
        bus_write(1'b0, 1'b0, 1'b1, 1'b1, 16'h0055);
        bus_write(1'b0, 1'b0, 1'b1, 1'b1, 16'h0066);
        bus_write(1'b0, 1'b1, 1'b0, 1'b1, 16'h0005);
        s_addr = c_addr; s_aerr = c_aerr;
        bus_write(1'b0, 1'b0, 1'b1, 1'b1, 16'h0077);
        bus_write(1'b0, 1'b0, 1'b1, 1'b1, 16'h0088);
        bus_write(1'b0, 1'b0, 1'b1, 1'b1, 16'h0099);
        chk(c_addr - s_addr == 1 && c_aerr == s_aerr, "R6 count cleared by command",
            c_addr - s_addr, 1);
        chk(last_addr == 24'h998877, "R6 partial address discarded", last_addr, 24'h998877);

        // R8: all opcodes under write protect, then protected ones released
        wp_n = 1'b0;
        wait_n(4);
        for (int op = 0; op < 256; op++) begin
            bit prot;
            prot = (op == 8'h80) || (op == 8'h10) || (op == 8'h60) || (op == 8'hD0);
            s_cmd = c_cmd; s_rej = c_rej;
            bus_write(1'b0, 1'b1, 1'b0, 1'b1, 16'hFF00 | 16'(op));
            chk((c_rej - s_rej) == int'(prot) && (c_cmd - s_cmd) == int'(!prot),
                "R8 protected opcode gate", c_rej - s_rej, prot);
            chk(last_cmd == 8'(op), "R8 opcode captured", last_cmd, op);
        end
        wp_n = 1'b1;
        wait_n(4);
        for (int j = 0; j < 4; j++) begin
            logic [7:0] op;
            op = (j == 0) ? 8'h80 : (j == 1) ? 8'h10 : (j == 2) ? 8'h60 : 8'hD0;
            s_cmd = c_cmd; s_rej = c_rej;
            bus_write(1'b0, 1'b1, 1'b0, 1'b1, {8'h00, op});
            chk(c_cmd - s_cmd == 1 && c_rej == s_rej, "R8 unprotected passes", c_cmd - s_cmd, 1);
        end

        // R9: output enable follows the output-cycle condition
        ce_n = 1'b0; cle = 1'b0; ale = 1'b0; we_n = 1'b1; re_n = 1'b1;
        wait_n(5);
        chk(io_oe == 1'b1, "R9 oe in output cycle", io_oe, 1);
        cle = 1'b1;
        wait_n(5);
        chk(io_oe == 1'b0, "R9 oe dropped by latch", io_oe, 0);
        cle = 1'b0;
        wait_n(5);
        chk(io_oe == 1'b1, "R9 oe restored", io_oe, 1);

        // R10: read stepping
        base = rd_idx;
        for (int k = 0; k < 5; k++) begin
            s_req = c_req;
            re_n = 1'b0;
            wait_n(6);
            chk(c_req - s_req == 1, "R10 one request per fall", c_req - s_req, 1);
            chk(io_out == model(base + k), "R10 stepped word", io_out, model(base + k));
            re_n = 1'b1;
            wait_n(4);
        end

        // R5: standby ignores reads and disables outputs
        ce_n = 1'b1;
        wait_n(5);
        chk(io_oe == 1'b0 && standby == 1'b1, "R5 standby drivers off", io_oe, 0);
        held = io_out;
        s_req = c_req;
        re_n = 1'b0;
        wait_n(6);
        re_n = 1'b1;
        wait_n(6);
        chk(c_req == s_req && io_out == held, "R5 read edge ignored", io_out, held);

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule